// File: doc/BRIEF.md
# ECC Syndrome Classifier

This block sorts the 7-bit check syndrome of a 32-bit memory word into an error class. A memory controller presents the syndrome together with two flags: a syndrome-valid flag, and a hint from the checking hardware that the error looks like a single-bit error. One clock after an input strobe, the block returns a registered verdict. The verdict gives the error class, the bit position where one can be named, whether that position is a check bit or a data bit, and a one-cycle request to scrub the word.

The hint is not trusted on its own. A fixed list of 25 syndromes that only several flipped bits can produce is tested first, and a match overrides the hint. A one-hot syndrome names a check bit, and the lowest syndrome bit stands for the extra check bit. A lookup against the 32 data-bit syndromes names the flipped data bit. The block does not flip the bit or rewrite memory. It only supplies what the caller needs to decide on a scrub.

Top module: `ecc_syndrome_sorter`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle with `in_valid` high and low otherwise; `class_code`, `position` and `pos_is_check` change only on a cycle that follows `in_valid` high, and otherwise hold their last value.
- R2: With `syn_valid` low, the class is INVALID (code 0), whatever the syndrome and hint.
- R3: With `syn_valid` high, a syndrome in the set {07,0D,1F,2F,32,37,38,3B,3D,3E,43,45,46,49,4C,51,5E,61,6E,73,76,79,7A,7C,7F} (hex) gives class MULTI (code 6), whatever the hint.
- R4: A valid zero syndrome gives class NONE (code 1), whatever the hint.
- R5: A valid, nonzero syndrome that is not in the R3 set, with `single_hint` low, gives class DOUBLE (code 5).
- R6: With the hint high, a one-hot syndrome gives class CHECK (code 3) with `pos_is_check` = 1. Syndrome 01 is the extra check bit and reports position 31. Any other one-hot syndrome s reports position s>>2, so 02,04,08,10,20,40 give 0,1,2,4,8,16.
- R7: With the hint high, a syndrome equal to the code of data bit Dk gives class DATA (code 2) with position k and `pos_is_check` = 0. The codes for D0 to D31 are, in order: 4F,4A,52,54,57,58,5B,5D,23,25,26,29,2A,2C,31,34,0E,0B,13,15,16,19,1A,1C,62,64,67,68,6B,6D,70,75.
- R8: With the hint high, any other nonzero syndrome outside the R3 set gives class UNKNOWN (code 4).
- R9: `scrub_req` is high together with `out_valid` exactly when the class is 2, 3 or 4. For classes 0, 1, 4, 5 and 6, `position` is 0 and `pos_is_check` is 0.
- R10: After reset, `out_valid`, `scrub_req`, `class_code`, `position` and `pos_is_check` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| syn_valid | input | 1 | Syndrome holds a captured error |
| single_hint | input | 1 | Hardware single-error hint |
| syndrome | input | 7 | Check syndrome |
| out_valid | output | 1 | Verdict strobe |
| class_code | output | 3 | Error class (0 INVALID, 1 NONE, 2 DATA, 3 CHECK, 4 UNKNOWN, 5 DOUBLE, 6 MULTI) |
| position | output | 5 | Bit index, or 31 for the extra check bit |
| pos_is_check | output | 1 | Position names a check bit |
| scrub_req | output | 1 | One-cycle request to rewrite the word |

## Verification
The hardest case to reach is a conflict between two rules. One is a syndrome that the hint calls single but that lies in the multi-bit set. The other is a one-hot or data-bit syndrome arriving with the hint clear. Only the order of the priority chain separates these, so a reordered chain fails only on those few codes. The stimulus therefore sweeps all 128 syndromes under every combination of hint and valid flag. Each sweep vector is followed by an idle cycle with a different syndrome on the input, which checks that the verdict holds.

// File: rtl/ecc_sort_pkg.sv
package ecc_sort_pkg;

   localparam int SYN_W   = 7;
   localparam int DATA_W  = 32;
   localparam int MULTI_N = 25;
   localparam int POS_W   = 5;

   typedef enum logic [2:0] {
      CLS_INVALID = 3'd0,
      CLS_NONE    = 3'd1,
      CLS_DATA    = 3'd2,
      CLS_CHECK   = 3'd3,
      CLS_UNKNOWN = 3'd4,
      CLS_DOUBLE  = 3'd5,
      CLS_MULTI   = 3'd6
   } cls_e;

   // Syndrome produced by a flip of data bit idx
   function automatic logic [SYN_W-1:0] data_code(input int idx);
      case (idx)
         0:  return 7'h4F;  1:  return 7'h4A;  2:  return 7'h52;  3:  return 7'h54;
         4:  return 7'h57;  5:  return 7'h58;  6:  return 7'h5B;  7:  return 7'h5D;
         8:  return 7'h23;  9:  return 7'h25;  10: return 7'h26;  11: return 7'h29;
         12: return 7'h2A;  13: return 7'h2C;  14: return 7'h31;  15: return 7'h34;
         16: return 7'h0E;  17: return 7'h0B;  18: return 7'h13;  19: return 7'h15;
         20: return 7'h16;  21: return 7'h19;  22: return 7'h1A;  23: return 7'h1C;
         24: return 7'h62;  25: return 7'h64;  26: return 7'h67;  27: return 7'h68;
         28: return 7'h6B;  29: return 7'h6D;  30: return 7'h70;  31: return 7'h75;
         default: return 7'h00;
      endcase
   endfunction

   // Syndromes reachable only through several flipped bits
   function automatic logic [SYN_W-1:0] multi_code(input int idx);
      case (idx)
         0:  return 7'h07;  1:  return 7'h0D;  2:  return 7'h1F;  3:  return 7'h2F;
         4:  return 7'h32;  5:  return 7'h37;  6:  return 7'h38;  7:  return 7'h3B;
         8:  return 7'h3D;  9:  return 7'h3E;  10: return 7'h43;  11: return 7'h45;
         12: return 7'h46;  13: return 7'h49;  14: return 7'h4C;  15: return 7'h51;
         16: return 7'h5E;  17: return 7'h61;  18: return 7'h6E;  19: return 7'h73;
         20: return 7'h76;  21: return 7'h79;  22: return 7'h7A;  23: return 7'h7C;
         24: return 7'h7F;
         default: return 7'h00;
      endcase
   endfunction

endpackage

// File: rtl/ecc_multi_match.sv
module ecc_multi_match
   import ecc_sort_pkg::*;
#(
   parameter int W = SYN_W,
   parameter int N = MULTI_N
) (
   input  logic [W-1:0] syndrome,
   output logic         hit
);
   if (N < 1) begin : g_bad_n
      $error("ecc_multi_match: N must be positive");
   end

   logic [N-1:0] eq_vec;

   for (genvar i = 0; i < N; i++) begin : g_cmp
      localparam logic [W-1:0] CODE = W'(multi_code(i));
      assign eq_vec[i] = (syndrome == CODE);
   end

   assign hit = |eq_vec;
endmodule

// File: rtl/ecc_data_locate.sv
module ecc_data_locate
   import ecc_sort_pkg::*;
#(
   parameter int W     = SYN_W,
   parameter int NBITS = DATA_W,
   parameter int PW    = POS_W
) (
   input  logic [W-1:0]  syndrome,
   output logic          hit,
   output logic [PW-1:0] index
);
   if (PW < $clog2(NBITS)) begin : g_bad_pw
      $error("ecc_data_locate: PW too narrow for NBITS");
   end

   logic [NBITS-1:0] eq_vec;

   for (genvar i = 0; i < NBITS; i++) begin : g_cmp
      localparam logic [W-1:0] CODE = W'(data_code(i));
      assign eq_vec[i] = (syndrome == CODE);
   end

   // Codes are distinct, so an OR encoder is enough
   always_comb begin
      index = '0;
      for (int i = 0; i < NBITS; i++) begin
         if (eq_vec[i]) index = index | PW'(i);
      end
   end

   assign hit = |eq_vec;
endmodule

// File: rtl/ecc_check_locate.sv
module ecc_check_locate #(
   parameter int W       = 7,
   parameter int PW      = 5,
   parameter int XPOS    = 31,
   parameter bit XREPORT = 1'b1
) (
   input  logic [W-1:0]  syndrome,
   output logic          hit,
   output logic [PW-1:0] index
);
   localparam logic [W-1:0] ONE = W'(1);

   if (XPOS >= (1 << PW)) begin : g_bad_xpos
      $error("ecc_check_locate: XPOS does not fit in PW bits");
   end

   logic single_one;
   assign single_one = (syndrome != '0) && ((syndrome & (syndrome - ONE)) == '0);

   logic [PW-1:0] shifted;
   assign shifted = PW'(syndrome >> 2);

   if (XREPORT) begin : g_xpos_code
      assign index = (syndrome == ONE) ? PW'(XPOS) : shifted;
   end else begin : g_xpos_plain
      assign index = shifted;
   end

   assign hit = single_one;
endmodule

// File: rtl/ecc_syndrome_sorter.sv
module ecc_syndrome_sorter
   import ecc_sort_pkg::*;
#(
   parameter int SW   = SYN_W,
   parameter int PW   = POS_W,
   parameter int XPOS = 31
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          syn_valid,
   input  logic          single_hint,
   input  logic [6:0]    syndrome,
   output logic          out_valid,
   output logic [2:0]    class_code,
   output logic [4:0]    position,
   output logic          pos_is_check,
   output logic          scrub_req
);
   if (SW != 7) begin : g_bad_sw
      $error("ecc_syndrome_sorter: code tables assume a 7-bit syndrome");
   end
   if (PW != 5) begin : g_bad_pw
      $error("ecc_syndrome_sorter: position port is 5 bits");
   end

   logic          multi_hit;
   logic          data_hit;
   logic          chk_hit;
   logic [PW-1:0] data_idx;
   logic [PW-1:0] chk_idx;

   ecc_multi_match #(.W(SW), .N(MULTI_N)) u_multi (
      .syndrome (syndrome),
      .hit      (multi_hit)
   );

   ecc_data_locate #(.W(SW), .NBITS(DATA_W), .PW(PW)) u_data (
      .syndrome (syndrome),
      .hit      (data_hit),
      .index    (data_idx)
   );

   ecc_check_locate #(.W(SW), .PW(PW), .XPOS(XPOS), .XREPORT(1'b1)) u_check (
      .syndrome (syndrome),
      .hit      (chk_hit),
      .index    (chk_idx)
   );

   cls_e          cls_d;
   logic [PW-1:0] pos_d;
   logic          chk_d;
   logic          scrub_d;

   // Priority chain: validity, multi set, zero, hint, then location
   always_comb begin
      cls_d = CLS_INVALID;
      pos_d = '0;
      chk_d = 1'b0;
      if (!syn_valid) begin
         cls_d = CLS_INVALID;
      end else if (multi_hit) begin
         cls_d = CLS_MULTI;
      end else if (syndrome == '0) begin
         cls_d = CLS_NONE;
      end else if (!single_hint) begin
         cls_d = CLS_DOUBLE;
      end else if (chk_hit) begin
         cls_d = CLS_CHECK;
         pos_d = chk_idx;
         chk_d = 1'b1;
      end else if (data_hit) begin
         cls_d = CLS_DATA;
         pos_d = data_idx;
      end else begin
         cls_d = CLS_UNKNOWN;
      end
   end

   assign scrub_d = (cls_d == CLS_DATA) || (cls_d == CLS_CHECK) || (cls_d == CLS_UNKNOWN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         scrub_req    <= 1'b0;
         class_code   <= CLS_INVALID;
         position     <= '0;
         pos_is_check <= 1'b0;
      end else begin
         out_valid <= in_valid;
         scrub_req <= in_valid & scrub_d;
         if (in_valid) begin
            class_code   <= cls_d;
            position     <= pos_d;
            pos_is_check <= chk_d;
         end
      end
   end
endmodule

// File: rtl/ecc_syndrome_sorter_chk.sv
module ecc_syndrome_sorter_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       syn_valid,
   input logic       single_hint,
   input logic [6:0] syndrome,
   input logic       out_valid,
   input logic [2:0] class_code,
   input logic [4:0] position,
   input logic       pos_is_check,
   input logic       scrub_req
);
   assert_strobe_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_strobe_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_verdict_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(class_code) && $stable(position) && $stable(pos_is_check)));

   assert_invalid_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !syn_valid) |=> (class_code == 3'd0 && !scrub_req));

   assert_zero_none_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && syn_valid && syndrome == 7'd0) |=> (class_code == 3'd1));

   assert_hint_clear_no_scrub_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !single_hint) |=> !scrub_req);

   assert_check_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pos_is_check |-> (class_code == 3'd3));

   assert_scrub_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
      scrub_req |-> (out_valid && (class_code == 3'd2 || class_code == 3'd3 || class_code == 3'd4)));
endmodule

bind ecc_syndrome_sorter ecc_syndrome_sorter_chk u_chk (.*);

// File: tb/ecc_syndrome_sorter_tb.sv
`timescale 1ns/1ps
module ecc_syndrome_sorter_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       syn_valid = 1'b0;
   logic       single_hint = 1'b0;
   logic [6:0] syndrome = 7'd0;
   logic       out_valid;
   logic [2:0] class_code;
   logic [4:0] position;
   logic       pos_is_check;
   logic       scrub_req;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   ecc_syndrome_sorter u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .syn_valid(syn_valid),
      .single_hint(single_hint), .syndrome(syndrome), .out_valid(out_valid),
      .class_code(class_code), .position(position), .pos_is_check(pos_is_check),
      .scrub_req(scrub_req)
   );

   function automatic bit in_multi(input logic [6:0] s);
      return s inside {7'h07,7'h0D,7'h1F,7'h2F,7'h32,7'h37,7'h38,7'h3B,7'h3D,7'h3E,
                       7'h43,7'h45,7'h46,7'h49,7'h4C,7'h51,7'h5E,7'h61,7'h6E,7'h73,
                       7'h76,7'h79,7'h7A,7'h7C,7'h7F};
   endfunction

   // Returns data bit index or -1
   function automatic int data_bit(input logic [6:0] s);
      case (s)
         7'h4F: return 0;  7'h4A: return 1;  7'h52: return 2;  7'h54: return 3;
         7'h57: return 4;  7'h58: return 5;  7'h5B: return 6;  7'h5D: return 7;
         7'h23: return 8;  7'h25: return 9;  7'h26: return 10; 7'h29: return 11;
         7'h2A: return 12; 7'h2C: return 13; 7'h31: return 14; 7'h34: return 15;
         7'h0E: return 16; 7'h0B: return 17; 7'h13: return 18; 7'h15: return 19;
         7'h16: return 20; 7'h19: return 21; 7'h1A: return 22; 7'h1C: return 23;
         7'h62: return 24; 7'h64: return 25; 7'h67: return 26; 7'h68: return 27;
         7'h6B: return 28; 7'h6D: return 29; 7'h70: return 30; 7'h75: return 31;
         default: return -1;
      endcase
   endfunction

   task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h (ov,cls,pos,chk,scrub)", req, act, exp);
      end
   endtask

   // Drive one vector, check the verdict, then an idle cycle checks the hold
   task automatic apply(input logic v, input logic h, input logic [6:0] s);
      logic [2:0] ec;
      logic [4:0] ep;
      logic       ek;
      logic       es;
      string      req;
      int         db;
      ep = 5'd0; ek = 1'b0;
      db = data_bit(s);
      if (!v)                  begin ec = 3'd0; req = "R2"; end
      else if (in_multi(s))    begin ec = 3'd6; req = "R3"; end
      else if (s == 7'd0)      begin ec = 3'd1; req = "R4"; end
      else if (!h)             begin ec = 3'd5; req = "R5"; end
      else if ((s & (s - 7'd1)) == 7'd0) begin
         ec = 3'd3; ek = 1'b1; req = "R6";
         ep = (s == 7'd1) ? 5'd31 : 5'(s >> 2);
      end
      else if (db >= 0)        begin ec = 3'd2; ep = 5'(db); req = "R7"; end
      else                     begin ec = 3'd4; req = "R8"; end
      es = (ec == 3'd2) || (ec == 3'd3) || (ec == 3'd4);
      @(negedge clk);
      in_valid = 1'b1; syn_valid = v; single_hint = h; syndrome = s;
      @(negedge clk);
      check(req, {out_valid, class_code, position, pos_is_check},
                 {1'b1, ec, ep, ek});
      check("R9", {9'd0, scrub_req}, {9'd0, es});
      in_valid = 1'b0; syn_valid = ~v; single_hint = ~h; syndrome = ~s;
      @(negedge clk);
      check("R1", {out_valid, class_code, position, pos_is_check, scrub_req},
                  {1'b0, ec, ep, ek, 1'b0});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R10", {out_valid, class_code, position, pos_is_check, scrub_req}, 10'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", {out_valid, class_code, position, pos_is_check, scrub_req}, 10'd0);
      for (int v = 0; v < 2; v++) begin
         for (int h = 0; h < 2; h++) begin
            for (int s = 0; s < 128; s++) begin
               apply(v[0], h[0], 7'(s));
            end
         end
      end
      // Back-to-back strobes: two verdicts in consecutive cycles
      @(negedge clk);
      in_valid = 1'b1; syn_valid = 1'b1; single_hint = 1'b1; syndrome = 7'h75;
      @(negedge clk);
      check("R7", {out_valid, class_code, position, pos_is_check}, {1'b1, 3'd2, 5'd31, 1'b0});
      syndrome = 7'h40;
      @(negedge clk);
      check("R6", {out_valid, class_code, position, pos_is_check}, {1'b1, 3'd3, 5'd16, 1'b1});
      check("R9", {9'd0, scrub_req}, 10'd1);
      in_valid = 1'b0;
      @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule